// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

This block joins two 8-input interrupt controllers, a primary and a secondary, into one unit that serves fifteen request lines. Each controller holds three 8-bit registers: pending requests, requests in service, and a mask. Together they drive one interrupt line to the processor. Each request line can latch on a rising edge or follow a high level, chosen line by line. The secondary's combined request enters primary input 2, so lines 8 to 15 rank below lines 0 and 1 and above lines 3 to 7.

The processor answers the interrupt with two acknowledge pulses. The first pulse freezes priority resolution and moves the winning request into service. When that pulse ends, the primary places a 3-bit identifier on a cascade bus. The identifier is 2 if the secondary owns the interrupt and 0 otherwise. On the second pulse, the owning controller returns an 8-bit vector made of its programmed base and the line index. A small write port loads the vector base and the mask, and issues end-of-service commands, to either controller.

Top module: `cascaded_irq_pair`

## Requirements
- R1: After reset, `intr_o`, `cas_o` and `vec_valid_o` are 0, the registers are clear and every line is masked, so a rising request raises no interrupt.
- R2: In edge mode (`level_i` bit = 0), a request is latched on a low-to-high transition of its line. A line held high after service does not request again until it falls and rises.
- R3: In level mode (`level_i` bit = 1), a line requests while it is high and stops requesting once it goes low. It requests again after end-of-service if it is still high.
- R4: A masked line never causes `intr_o`. A request latched while masked raises `intr_o` once its mask bit is cleared. Mask bit n (write command 1) covers input n of the addressed controller.
- R5: Priority is fixed, and the lowest input index wins. The secondary's lines 8 to 15 rank between primary lines 1 and 3.
- R6: A request is forwarded only if its input is above every input already in service in that controller. An equal or lower request waits, and a higher one nests.
- R7: The first acknowledge pulse moves the winner into service and clears its request. `intr_o` drops unless another request can still be forwarded.
- R8: After the first pulse ends, `cas_o` reads 2 when the secondary owns the interrupt and 0 otherwise. It returns to 0 after the second pulse ends.
- R9: The second pulse produces a one-cycle `vec_valid_o`. `vec_o[7:3]` then carries the owning controller's base (write command 0, data bits 7:3), and `vec_o[2:0]` carries the input index within that controller.
- R10: An end-of-service command (write command 2) clears the highest-priority in-service bit of the addressed controller (`wr_sel_i` 0 = primary, 1 = secondary). A secondary interrupt needs end-of-service at both controllers.
- R11: If no request is pending at the first pulse, the controller returns the vector for input 7 and puts nothing in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines; bits 7:0 primary (bit 2 unused), 15:8 secondary |
| level_i | input | 16 | Per-line mode: 1 = level, 0 = edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Target controller: 0 primary, 1 secondary |
| wr_cmd_i | input | 2 | 0 = vector base, 1 = mask, 2 = end-of-service |
| wr_data_i | input | 8 | Write data |
| inta_i | input | 1 | Acknowledge pulse, active high |
| intr_o | output | 1 | Interrupt to the processor |
| cas_o | output | 3 | Cascade identifier broadcast by the primary |
| vec_o | output | 8 | Returned vector |
| vec_valid_o | output | 1 | One-cycle strobe marking `vec_o` |

## Verification
The assertions check several properties on every cycle:
- the cascade bus only ever carries 0 or the secondary's identifier;
- the bus changes only just after an acknowledge pulse has ended;
- the vector strobe lasts exactly one cycle and follows the start of a pulse;
- the outputs are idle during reset.

The vector values, the fixed priority order across the two controllers, the blocking by in-service bits, the need for end-of-service at both controllers, edge and level latching, masking, and the spurious input-7 answer depend on earlier history. Only the bench's scenarios can show these.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;

   typedef enum logic [1:0] {
      CMD_BASE = 2'd0,
      CMD_MASK = 2'd1,
      CMD_EOS  = 2'd2
   } irq_cmd_e;

   localparam int unsigned CTRL_LINES = 8;

   // one-hot of the lowest set bit, zero when none is set
   function automatic logic [CTRL_LINES-1:0] lowest_one(input logic [CTRL_LINES-1:0] v);
      logic [CTRL_LINES-1:0] r;
      r = '0;
      for (int i = CTRL_LINES - 1; i >= 0; i--) begin
         if (v[i]) r = CTRL_LINES'(1) << i;
      end
      return r;
   endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N  = 8,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   input  logic [N-1:0]  isr_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);

   if (N < 2) begin : g_bad_n
      $error("irq_prio_pick: N must be at least 2");
   end

   logic blocked;

   // scan from highest priority (index 0); an in-service bit stops the scan
   always_comb begin
      any_o   = 1'b0;
      idx_o   = '0;
      blocked = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!blocked && !any_o) begin
            if (isr_i[i]) begin
               blocked = 1'b1;
            end else if (req_i[i]) begin
               any_o = 1'b1;
               idx_o = IW'(i);
            end
         end
      end
   end

endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
   import irq_pair_pkg::*;
#(
   parameter int unsigned LINES       = 8,
   parameter int unsigned VEC_W       = 8,
   parameter bit          IS_PRIMARY  = 1'b1,
   parameter logic [LINES-1:0] CASCADE_MAP = '0,
   parameter int unsigned OWN_ID      = 2,
   localparam int unsigned IDX_W      = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_i,
   input  logic [LINES-1:0] level_i,
   input  logic             wr_en_i,
   input  irq_cmd_e         wr_cmd_i,
   input  logic [VEC_W-1:0] wr_data_i,
   input  logic             inta_i,
   input  logic [IDX_W-1:0] cas_i,
   output logic             int_o,
   output logic [IDX_W-1:0] cas_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             vec_vld_o
);

   localparam int unsigned BASE_W = VEC_W - IDX_W;

   if ((1 << IDX_W) != LINES || LINES != CTRL_LINES) begin : g_bad_lines
      $error("irq_ctrl_core: LINES must equal the package line count, a power of two");
   end
   if (VEC_W <= IDX_W || VEC_W < LINES) begin : g_bad_vec
      $error("irq_ctrl_core: VEC_W too narrow");
   end
   if (OWN_ID >= LINES) begin : g_bad_id
      $error("irq_ctrl_core: OWN_ID out of range");
   end

   logic [LINES-1:0]  line_q, irr_q, isr_q, imr_q;
   logic [BASE_W-1:0] base_q;
   logic              inta_q, phase_q;
   logic [IDX_W-1:0]  pick_q;
   logic              pick_vld_q;

   logic              cand_any;
   logic [IDX_W-1:0]  cand_idx;
   logic              ack_rise, ack_fall;
   logic              commit_now, commit_vld, respond;
   logic [IDX_W-1:0]  commit_idx;
   logic [LINES-1:0]  set_mask, eos_clr, irr_next;

   irq_prio_pick #(.N(LINES), .IW(IDX_W)) u_pick (
      .req_i (irr_q & ~imr_q),
      .isr_i (isr_q),
      .any_o (cand_any),
      .idx_o (cand_idx)
   );

   assign int_o    = cand_any;
   assign ack_rise = inta_i & ~inta_q;
   assign ack_fall = ~inta_i & inta_q;

   // variant: where the in-service commit happens and who answers pulse two
   if (IS_PRIMARY) begin : g_primary
      logic [IDX_W-1:0] cas_q;
      logic             to_cascade;

      assign to_cascade = pick_vld_q && CASCADE_MAP[pick_q];
      assign commit_now = ack_rise && !phase_q;
      assign commit_idx = cand_idx;
      assign commit_vld = cand_any;
      assign respond    = !to_cascade;
      assign cas_o      = cas_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cas_q <= '0;
         end else if (ack_fall) begin
            cas_q <= (!phase_q && to_cascade) ? pick_q : '0;
         end
      end
   end else begin : g_secondary
      logic done_q;
      logic selected;

      assign selected   = (cas_i == IDX_W'(OWN_ID));
      assign commit_now = phase_q && selected && !done_q;
      assign commit_idx = pick_q;
      assign commit_vld = pick_vld_q;
      assign respond    = selected;
      assign cas_o      = '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done_q <= 1'b0;
         end else if (ack_fall && phase_q) begin
            done_q <= 1'b0;
         end else if (commit_now) begin
            done_q <= 1'b1;
         end
      end
   end

   always_comb begin
      set_mask = '0;
      if (commit_now && commit_vld) set_mask[commit_idx] = 1'b1;
      eos_clr = (wr_en_i && wr_cmd_i == CMD_EOS) ? lowest_one(isr_q) : '0;
      for (int i = 0; i < LINES; i++) begin
         irr_next[i] = level_i[i] ? line_i[i] : (irr_q[i] | (line_i[i] & ~line_q[i]));
      end
      irr_next = irr_next & ~set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q     <= '0;
         irr_q      <= '0;
         isr_q      <= '0;
         imr_q      <= '1;
         base_q     <= '0;
         inta_q     <= 1'b0;
         phase_q    <= 1'b0;
         pick_q     <= '0;
         pick_vld_q <= 1'b0;
         vec_o      <= '0;
         vec_vld_o  <= 1'b0;
      end else begin
         line_q    <= line_i;
         irr_q     <= irr_next;
         isr_q     <= (isr_q & ~eos_clr) | set_mask;
         inta_q    <= inta_i;
         vec_vld_o <= 1'b0;
         if (wr_en_i && wr_cmd_i == CMD_MASK) imr_q  <= wr_data_i[LINES-1:0];
         if (wr_en_i && wr_cmd_i == CMD_BASE) base_q <= wr_data_i[VEC_W-1:IDX_W];
         if (ack_fall) phase_q <= ~phase_q;
         if (ack_rise && !phase_q) begin
            pick_q     <= cand_idx;
            pick_vld_q <= cand_any;
         end
         if (ack_rise && phase_q && respond) begin
            vec_o     <= {base_q, (pick_vld_q ? pick_q : {IDX_W{1'b1}})};
            vec_vld_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cascaded_irq_pair.sv
module cascaded_irq_pair
   import irq_pair_pkg::*;
#(
   parameter int unsigned LINES       = 8,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned SLAVE_INPUT = 2,
   localparam int unsigned IDX_W      = $clog2(LINES),
   localparam int unsigned ALL_W      = 2 * LINES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ALL_W-1:0] irq_i,
   input  logic [ALL_W-1:0] level_i,
   input  logic             wr_en_i,
   input  logic             wr_sel_i,
   input  logic [1:0]       wr_cmd_i,
   input  logic [VEC_W-1:0] wr_data_i,
   input  logic             inta_i,
   output logic             intr_o,
   output logic [IDX_W-1:0] cas_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             vec_valid_o
);

   localparam logic [LINES-1:0] CAS_MAP = LINES'(1) << SLAVE_INPUT;

   if (SLAVE_INPUT >= LINES) begin : g_bad_slot
      $error("cascaded_irq_pair: SLAVE_INPUT out of range");
   end

   irq_cmd_e         cmd;
   logic             sec_int;
   logic [LINES-1:0] pri_lines, pri_level;
   logic [IDX_W-1:0] sec_cas_unused;
   logic [VEC_W-1:0] pri_vec, sec_vec;
   logic             pri_vld, sec_vld;

   assign cmd = irq_cmd_e'(wr_cmd_i);

   always_comb begin
      pri_lines = irq_i[LINES-1:0];
      pri_level = level_i[LINES-1:0];
      pri_lines[SLAVE_INPUT] = sec_int;
      pri_level[SLAVE_INPUT] = 1'b1;
   end

   irq_ctrl_core #(
      .LINES(LINES), .VEC_W(VEC_W), .IS_PRIMARY(1'b1),
      .CASCADE_MAP(CAS_MAP), .OWN_ID(0)
   ) u_primary (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (pri_lines),
      .level_i   (pri_level),
      .wr_en_i   (wr_en_i && !wr_sel_i),
      .wr_cmd_i  (cmd),
      .wr_data_i (wr_data_i),
      .inta_i    (inta_i),
      .cas_i     ('0),
      .int_o     (intr_o),
      .cas_o     (cas_o),
      .vec_o     (pri_vec),
      .vec_vld_o (pri_vld)
   );

   irq_ctrl_core #(
      .LINES(LINES), .VEC_W(VEC_W), .IS_PRIMARY(1'b0),
      .CASCADE_MAP('0), .OWN_ID(SLAVE_INPUT)
   ) u_secondary (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (irq_i[ALL_W-1:LINES]),
      .level_i   (level_i[ALL_W-1:LINES]),
      .wr_en_i   (wr_en_i && wr_sel_i),
      .wr_cmd_i  (cmd),
      .wr_data_i (wr_data_i),
      .inta_i    (inta_i),
      .cas_i     (cas_o),
      .int_o     (sec_int),
      .cas_o     (sec_cas_unused),
      .vec_o     (sec_vec),
      .vec_vld_o (sec_vld)
   );

   assign vec_valid_o = pri_vld | sec_vld;
   assign vec_o       = pri_vld ? pri_vec : sec_vec;

endmodule

// File: rtl/cascaded_irq_pair_chk.sv
module cascaded_irq_pair_chk #(
   parameter int unsigned IDX_W       = 3,
   parameter int unsigned SLAVE_INPUT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inta_i,
   input logic             intr_o,
   input logic [IDX_W-1:0] cas_o,
   input logic             vec_valid_o
);

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!intr_o && cas_o == '0 && !vec_valid_o));

   p_cas_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_o == '0) || (cas_o == IDX_W'(SLAVE_INPUT)));

   p_cas_set_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_o != '0) |-> (!$past(inta_i) && $past(inta_i, 2)));

   p_cas_clear_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_o != '0) |-> (!$past(inta_i) && $past(inta_i, 2)));

   p_vec_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |=> !vec_valid_o);

   p_vec_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> ($past(inta_i) && !$past(inta_i, 2)));

endmodule

bind cascaded_irq_pair cascaded_irq_pair_chk #(
   .IDX_W(IDX_W), .SLAVE_INPUT(SLAVE_INPUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .inta_i      (inta_i),
   .intr_o      (intr_o),
   .cas_o       (cas_o),
   .vec_valid_o (vec_valid_o)
);

// File: tb/cascaded_irq_pair_bench.sv
module cascaded_irq_pair_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq = '0;
   logic [15:0] level = '0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [1:0]  wr_cmd = 2'd0;
   logic [7:0]  wr_data = '0;
   logic        inta = 1'b0;
   logic        intr;
   logic [2:0]  cas;
   logic [7:0]  vec;
   logic        vec_valid;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   cascaded_irq_pair u_cascaded_irq_pair (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .level_i(level),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_cmd_i(wr_cmd), .wr_data_i(wr_data),
      .inta_i(inta), .intr_o(intr), .cas_o(cas), .vec_o(vec), .vec_valid_o(vec_valid)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [1:0] cmd, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_cmd = cmd; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: pushes the expected vector, runs both pulses, checks the cascade bus (R8)
   task automatic ack(input logic [7:0] exp_vec, input logic [2:0] exp_cas);
      exp_q.push_back(exp_vec);
      @(negedge clk); inta = 1'b1;
      settle(2);      inta = 1'b0;
      @(negedge clk);
      chk("R8", "cascade id after first pulse", cas, exp_cas);
      @(negedge clk); inta = 1'b1;
      settle(2);      inta = 1'b0;
      settle(2);
      chk("R8", "cascade idle after second pulse", cas, 3'd0);
      settle(2);
   endtask

   // monitor: compares each vector strobe with the scoreboard (R9)
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) begin
            chk("R9", "unexpected vector", vec, 8'hxx);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk("R9", "vector", vec, e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      settle(4);
      rst_n = 1'b1;
      settle(1);
      chk("R1", "intr after reset", intr, 1'b0);
      chk("R1", "cas after reset", cas, 3'd0);
      chk("R1", "vec_valid after reset", vec_valid, 1'b0);
      wr(0, 2'd0, 8'h20);
      wr(1, 2'd0, 8'h70);
      irq[0] = 1'b1; settle(6);
      chk("R1", "masked by reset", intr, 1'b0);
      wr(0, 2'd1, 8'hFE); settle(3);
      chk("R4", "pending edge seen after unmask", intr, 1'b1);
      ack(8'h20, 3'd0);
      chk("R7", "intr dropped after acknowledge", intr, 1'b0);
      wr(0, 2'd2, 8'h00); irq[0] = 1'b0;
      wr(0, 2'd1, 8'h00); wr(1, 2'd1, 8'h00); settle(4);
      chk("R2", "no request without new edge", intr, 1'b0);

      // R5: secondary line 9 outranks primary line 3
      irq[3] = 1'b1; irq[9] = 1'b1; settle(6);
      chk("R5", "intr with two requests", intr, 1'b1);
      ack(8'h71, 3'd2);
      chk("R6", "line 3 blocked by cascade in service", intr, 1'b0);
      wr(1, 2'd2, 8'h00); settle(4);
      chk("R10", "secondary end only keeps block", intr, 1'b0);
      wr(0, 2'd2, 8'h00); settle(4);
      chk("R10", "both ends release line 3", intr, 1'b1);
      ack(8'h23, 3'd0);
      wr(0, 2'd2, 8'h00);
      irq[3] = 1'b0; irq[9] = 1'b0;

      // R4 on the secondary: mask bit 3 covers line 11
      wr(1, 2'd1, 8'h08);
      irq[11] = 1'b1; settle(6);
      chk("R4", "masked secondary line", intr, 1'b0);
      wr(1, 2'd1, 8'h00); settle(6);
      chk("R4", "secondary line after unmask", intr, 1'b1);
      ack(8'h73, 3'd2);
      wr(1, 2'd2, 8'h00); wr(0, 2'd2, 8'h00);
      irq[11] = 1'b0; settle(4);

      // R6 nesting
      irq[5] = 1'b1; settle(4);
      ack(8'h25, 3'd0);
      irq[6] = 1'b1; settle(4);
      chk("R6", "lower line waits", intr, 1'b0);
      irq[0] = 1'b1; settle(4);
      chk("R6", "higher line nests", intr, 1'b1);
      ack(8'h20, 3'd0);
      wr(0, 2'd2, 8'h00); settle(3);
      chk("R10", "end clears only highest", intr, 1'b0);
      wr(0, 2'd2, 8'h00); settle(3);
      chk("R10", "second end releases line 6", intr, 1'b1);
      ack(8'h26, 3'd0);
      wr(0, 2'd2, 8'h00); settle(4);
      chk("R2", "held lines do not re-request", intr, 1'b0);
      irq[0] = 1'b0; irq[5] = 1'b0; irq[6] = 1'b0; settle(2);

      // R3 level mode and R11 spurious answer
      level[4] = 1'b1;
      irq[4] = 1'b1; settle(4);
      chk("R3", "level line requests", intr, 1'b1);
      irq[4] = 1'b0; settle(4);
      chk("R3", "level request withdrawn", intr, 1'b0);
      ack(8'h27, 3'd0);
      irq[7] = 1'b1; settle(4);
      chk("R11", "spurious left nothing in service", intr, 1'b1);
      ack(8'h27, 3'd0);
      wr(0, 2'd2, 8'h00); irq[7] = 1'b0;
      irq[4] = 1'b1; settle(4);
      ack(8'h24, 3'd0);
      wr(0, 2'd2, 8'h00); settle(4);
      chk("R3", "level line requests again", intr, 1'b1);
      ack(8'h24, 3'd0);
      wr(0, 2'd2, 8'h00);
      irq[4] = 1'b0; settle(4);
      chk("R3", "idle at end", intr, 1'b0);
      chk("R9", "scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule